// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block sits between a transmit cell buffer and the physical-layer framer. Each time the framer asks for a cell slot, the block sends exactly one 53-byte cell. If the buffer holds a complete cell at that moment, the block reads that cell from the buffer. If it does not, the block generates an idle/unassigned cell. The outgoing cell stream therefore never has holes while the framer keeps asking for slots.

On the way through, the block rewrites parts of every cell:

- **GFC nibble.** For assigned cells the nibble comes from the incoming data. For idle cells it comes from a configuration field. A per-bit mask can replace any of these bits with bits captured from a serial input.
- **Header error check.** Byte 5 of the header is computed from the first four header bytes.
- **Payload scrambling.** The 48 payload bytes can optionally pass through a self-synchronous x^43+1 scrambler.

The block is configured through static inputs. These inputs are changed only while no cell is in flight.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: While reset is held, out_valid, out_soc and in_rd are all low.
- R2: A slot request is taken when no cell is in progress, or in the cycle that handles the last byte of the current cell. A request taken at the end of cycle t yields 53 bytes on consecutive cycles. These bytes are visible from cycle t+2 onward, and out_soc is high on the first byte only. Requests at any other time are ignored.
- R3: If cell_avail is high when a request is taken, the cell is assigned. in_rd is then high for 53 consecutive cycles, one buffer byte per cycle, and each byte is output one cycle after its read.
- R4: An idle cell has the following content:

  | Byte | Value |
  |------|-------|
  | 1 | GFC nibble in bits 7:4, zeros in bits 3:0 |
  | 2 | 0x00 |
  | 3 | 0x00 |
  | 4 | zeros, then cfg_idle_pti in bits 3:1 and cfg_idle_clp in bit 0 |
  | 6 to 53 | 0x6A before scrambling |

- R5: With cfg_hec_en high, byte 5 of every cell is computed as follows. Take the CRC-8 remainder of output bytes 1 to 4, using generator 0x07 (x^8+x^2+x+1), a zero start value, and most significant bit first. XOR that remainder with 0x55.
- R6: With cfg_hec_en low, byte 5 is the buffer byte for an assigned cell and 0x00 for an idle cell.
- R7: With cfg_scr_en high, each payload bit is its input bit XOR the scrambled bit 43 positions earlier in the payload bit stream. Bits are taken most significant bit first within each byte. The history spans cells, including idle cells, and is zero after reset. Header bytes are never scrambled.
- R8: With cfg_scr_en low, payload bytes pass unchanged and the scrambler history does not advance.
- R9: The GFC nibble works bit by bit. Where cfg_gfc_mask bit i is set, the nibble takes bit i of the captured serial value. Elsewhere it takes buffer byte 1 bits 7:4 (assigned cells) or cfg_idle_gfc (idle cells).
- R10: gfc_ser_in is sampled in the four cycles that read bytes 1 to 4 of each cell, with bit 3 first. The captured value applies to the next cell. It is zero until the first cell completes, and gfc_ser_in is ignored in all other cycles.
- R11: out_valid is low in every cycle that carries no cell byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req | input | 1 | Downstream asks for the next cell slot |
| cell_avail | input | 1 | Buffer holds at least one complete cell |
| in_rd | output | 1 | Consumes the buffer byte on in_data this cycle |
| in_data | input | 8 | Current buffer byte |
| cfg_hec_en | input | 1 | Replace byte 5 with the computed check |
| cfg_scr_en | input | 1 | Scramble payload bytes |
| cfg_idle_gfc | input | 4 | GFC for idle cells |
| cfg_idle_pti | input | 3 | Payload-type field for idle cells |
| cfg_idle_clp | input | 1 | Loss-priority bit for idle cells |
| cfg_gfc_mask | input | 4 | Per-bit select of serial GFC |
| gfc_ser_in | input | 1 | Serial GFC bit stream |
| out_valid | output | 1 | out_data carries a cell byte |
| out_soc | output | 1 | First byte of a cell |
| out_data | output | 8 | Outgoing cell byte |

## Verification
Every output byte appears two cycles after the cycle in which its slot request was driven, plus its position in the cell. The in_rd for a byte is due exactly one cycle before that byte appears. A serial GFC value captured during one cell shows up only in the following cell's first byte.

The bench models this timing with a queue holding one expected entry per future cycle. It samples all outputs on the falling edge. It checks in_rd against the entry for the next cycle, so each result is compared in the cycle it is due.

// File: rtl/atm_txcp_pkg.sv
package atm_txcp_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {SEG_GFC, SEG_HDR, SEG_HEC, SEG_PAY} cell_seg_e;

   // one byte of serial CRC division, MSB first
   function automatic logic [BYTE_W-1:0] crc8_byte(input logic [BYTE_W-1:0] crc_in,
                                                   input logic [BYTE_W-1:0] din,
                                                   input logic [BYTE_W-1:0] poly);
      logic [BYTE_W-1:0] c;
      logic              fb;
      c = crc_in;
      for (int i = BYTE_W - 1; i >= 0; i--) begin
         fb = c[BYTE_W-1] ^ din[i];
         c  = {c[BYTE_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return c;
   endfunction

endpackage

// File: rtl/atm_txcp_hec.sv
module atm_txcp_hec
   import atm_txcp_pkg::*;
#(
   parameter logic [BYTE_W-1:0] POLY  = 8'h07,
   parameter logic [BYTE_W-1:0] COSET = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              first,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] hec
);

   logic [BYTE_W-1:0] crc_q;
   logic [BYTE_W-1:0] seed;

   assign seed = first ? '0 : crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= '0;
      else if (step)  crc_q <= crc8_byte(seed, din, POLY);
   end

   assign hec = crc_q ^ COSET;

   // R5
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(crc_q));

endmodule

// File: rtl/atm_txcp_scrambler.sv
module atm_txcp_scrambler #(
   parameter int unsigned LAG = 43,
   parameter int unsigned W   = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (LAG <= W) begin : g_bad_lag
         $error("scrambler lag must exceed the byte width");
      end
   endgenerate

   // newest scrambled bit at index 0
   logic [LAG-1:0] hist_q;

   assign dout = din ^ hist_q[LAG-1:LAG-W];

   always_ff @(posedge clk) begin
      if (!rst_n)    hist_q <= '0;
      else if (adv)  hist_q <= {hist_q[LAG-W-1:0], dout};
   end

   // R8
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(hist_q));

endmodule

// File: rtl/atm_txcp_gfc_ser.sv
module atm_txcp_gfc_ser #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         ser_in,
   input  logic         load,
   output logic [W-1:0] hold
);

   generate
      if (W < 2) begin : g_bad_w
         $error("serial GFC width must be at least two");
      end
   endgenerate

   logic [W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
         hold <= '0;
      end else begin
         if (shift) sh_q <= {sh_q[W-2:0], ser_in};
         if (load)  hold <= sh_q;
      end
   end

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(hold));

endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
   import atm_txcp_pkg::*;
#(
   parameter int unsigned       CELL_BYTES  = 53,
   parameter int unsigned       HDR_BYTES   = 5,
   parameter int unsigned       GFC_W       = 4,
   parameter int unsigned       PTI_W       = 3,
   parameter int unsigned       SCR_LAG     = 43,
   parameter bit                SCR_PRESENT = 1'b1,
   parameter logic [BYTE_W-1:0] HEC_POLY    = 8'h07,
   parameter logic [BYTE_W-1:0] HEC_COSET   = 8'h55,
   parameter logic [BYTE_W-1:0] IDLE_FILL   = 8'h6A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_req,
   input  logic              cell_avail,
   output logic              in_rd,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              cfg_hec_en,
   input  logic              cfg_scr_en,
   input  logic [GFC_W-1:0]  cfg_idle_gfc,
   input  logic [PTI_W-1:0]  cfg_idle_pti,
   input  logic              cfg_idle_clp,
   input  logic [GFC_W-1:0]  cfg_gfc_mask,
   input  logic              gfc_ser_in,
   output logic              out_valid,
   output logic              out_soc,
   output logic [BYTE_W-1:0] out_data
);

   localparam int unsigned      CNT_W    = $clog2(CELL_BYTES);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_BYTES - 1);
   localparam logic [CNT_W-1:0] HEC_IDX  = CNT_W'(HDR_BYTES - 1);
   localparam logic [CNT_W-1:0] PTI_IDX  = CNT_W'(HDR_BYTES - 2);
   localparam logic [CNT_W-1:0] SER_END  = CNT_W'(GFC_W);

   generate
      if (HDR_BYTES < 3 || HDR_BYTES >= CELL_BYTES) begin : g_bad_hdr
         $error("header length out of range");
      end
      if (GFC_W < 2 || GFC_W >= BYTE_W || GFC_W >= HDR_BYTES) begin : g_bad_gfc
         $error("GFC width out of range");
      end
      if (PTI_W + 1 > BYTE_W) begin : g_bad_pti
         $error("idle PTI field does not fit a byte");
      end
   endgenerate

   // cell sequencer
   logic             busy_q, assigned_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_byte, start;

   assign last_byte = busy_q && (cnt_q == LAST_IDX);
   assign start     = slot_req && (!busy_q || last_byte);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         assigned_q <= 1'b0;
         cnt_q      <= '0;
      end else if (start) begin
         busy_q     <= 1'b1;
         assigned_q <= cell_avail;
         cnt_q      <= '0;
      end else if (last_byte) begin
         busy_q     <= 1'b0;
      end else if (busy_q) begin
         cnt_q      <= cnt_q + CNT_W'(1);
      end
   end

   assign in_rd = busy_q && assigned_q;

   // segment of the current byte
   cell_seg_e seg;
   always_comb begin
      if (cnt_q == '0)          seg = SEG_GFC;
      else if (cnt_q < HEC_IDX) seg = SEG_HDR;
      else if (cnt_q == HEC_IDX) seg = SEG_HEC;
      else                      seg = SEG_PAY;
   end

   // raw byte: buffer or generated idle content
   logic [BYTE_W-1:0] idle_raw, raw;
   always_comb begin
      if (cnt_q > HEC_IDX)       idle_raw = IDLE_FILL;
      else if (cnt_q == PTI_IDX) idle_raw = BYTE_W'({cfg_idle_pti, cfg_idle_clp});
      else                       idle_raw = '0;
   end
   assign raw = assigned_q ? in_data : idle_raw;

   // GFC selection
   logic [GFC_W-1:0]  gfc_base, gfc_pick, ser_hold;
   logic [BYTE_W-1:0] hdr_byte;

   assign gfc_base = assigned_q ? in_data[BYTE_W-1 -: GFC_W] : cfg_idle_gfc;
   assign gfc_pick = (cfg_gfc_mask & ser_hold) | (~cfg_gfc_mask & gfc_base);
   assign hdr_byte = (seg == SEG_GFC) ? {gfc_pick, raw[BYTE_W-GFC_W-1:0]} : raw;

   atm_txcp_gfc_ser #(.W(GFC_W)) u_gfc_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift  (busy_q && (cnt_q < SER_END)),
      .ser_in (gfc_ser_in),
      .load   (last_byte),
      .hold   (ser_hold)
   );

   // header check
   logic [BYTE_W-1:0] hec;
   atm_txcp_hec #(.POLY(HEC_POLY), .COSET(HEC_COSET)) u_hec (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (busy_q && (seg == SEG_GFC || seg == SEG_HDR)),
      .first (seg == SEG_GFC),
      .din   (hdr_byte),
      .hec   (hec)
   );

   // payload scrambler variant
   logic [BYTE_W-1:0] scr_out;
   generate
      if (SCR_PRESENT) begin : g_scr
         logic adv;
         assign adv = busy_q && (seg == SEG_PAY) && cfg_scr_en;
         atm_txcp_scrambler #(.LAG(SCR_LAG), .W(BYTE_W)) u_scr (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .din   (raw),
            .dout  (scr_out)
         );
      end else begin : g_noscr
         assign scr_out = raw;
      end
   endgenerate

   logic [BYTE_W-1:0] byte_nxt;
   always_comb begin
      unique case (seg)
         SEG_HEC: byte_nxt = cfg_hec_en ? hec : raw;
         SEG_PAY: byte_nxt = cfg_scr_en ? scr_out : raw;
         default: byte_nxt = hdr_byte;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_soc   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= busy_q;
         out_soc   <= busy_q && (cnt_q == '0);
         out_data  <= busy_q ? byte_nxt : '0;
      end
   end

   // R2
   soc_in_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_soc |-> out_valid);

   // R2
   burst_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_soc);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= LAST_IDX));

   // R3
   rd_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_rd |=> out_valid);

endmodule

// File: tb/tb_atm_tx_cell_proc.sv
module tb_atm_tx_cell_proc;

   logic       clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, slot_req, cell_avail, in_rd;
   logic [7:0] in_data;
   logic       cfg_hec_en, cfg_scr_en, cfg_idle_clp, gfc_ser_in;
   logic [3:0] cfg_idle_gfc, cfg_gfc_mask;
   logic [2:0] cfg_idle_pti;
   logic       out_valid, out_soc;
   logic [7:0] out_data;

   atm_tx_cell_proc dut (
      .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .cell_avail(cell_avail),
      .in_rd(in_rd), .in_data(in_data), .cfg_hec_en(cfg_hec_en),
      .cfg_scr_en(cfg_scr_en), .cfg_idle_gfc(cfg_idle_gfc),
      .cfg_idle_pti(cfg_idle_pti), .cfg_idle_clp(cfg_idle_clp),
      .cfg_gfc_mask(cfg_gfc_mask), .gfc_ser_in(gfc_ser_in),
      .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
   );

   typedef struct {
      logic       v;
      logic       soc;
      logic [7:0] d;
      logic       rd;
      int         tag;
   } slot_t;

   slot_t      expq[$];
   logic [7:0] feedq[$];
   logic [7:0] mq[$];
   bit         hist[$];
   bit         serq[$];
   logic [3:0] hold_m;
   bit         rd_flag, req_on, done;
   int         n_cmp, n_bad;

   task automatic check(input int tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // R5: long division of header*x^8 by 0x107
   function automatic logic [7:0] hec_ref(input logic [7:0] b0, b1, b2, b3);
      logic [39:0] v;
      v = {b0, b1, b2, b3, 8'h00};
      for (int i = 39; i >= 8; i--)
         if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
      return v[7:0] ^ 8'h55;
   endfunction

   // R7: bit-serial x^43+1 reference on a bit queue (oldest first)
   function automatic logic [7:0] scr_byte(input logic [7:0] d);
      logic [7:0] o;
      for (int j = 7; j >= 0; j--) begin
         o[j] = d[j] ^ hist[0];
         void'(hist.pop_front());
         hist.push_back(o[j]);
      end
      return o;
   endfunction

   task automatic build_cell();
      logic [7:0] c[53];
      bit         asg;
      logic [3:0] sv;
      int         tg;
      asg = (mq.size() >= 53);
      if (asg) begin
         for (int i = 0; i < 53; i++) c[i] = mq.pop_front();
      end else begin
         // R4 idle layout
         for (int i = 0; i < 53; i++) c[i] = (i > 4) ? 8'h6A : 8'h00;
         c[0] = {cfg_idle_gfc, 4'h0};
         c[3] = {4'h0, cfg_idle_pti, cfg_idle_clp};
      end
      // R9 R10 per-bit serial override
      for (int b = 0; b < 4; b++)
         if (cfg_gfc_mask[b]) c[0][4+b] = hold_m[b];
      if (cfg_hec_en) c[4] = hec_ref(c[0], c[1], c[2], c[3]);
      if (cfg_scr_en)
         for (int i = 5; i < 53; i++) c[i] = scr_byte(c[i]);
      if (expq.size() == 0) expq.push_back('{1'b0, 1'b0, 8'h00, 1'b0, 11});
      for (int i = 0; i < 53; i++) begin
         if (i == 0)      tg = (cfg_gfc_mask != 0) ? 10 : (asg ? 9 : 4);
         else if (i < 4)  tg = asg ? 3 : 4;
         else if (i == 4) tg = cfg_hec_en ? 5 : 6;
         else             tg = cfg_scr_en ? 7 : 8;
         expq.push_back('{1'b1, (i == 0), c[i], asg, tg});
      end
      sv = 4'($urandom);
      for (int b = 3; b >= 0; b--) serq.push_back(sv[b]);
      hold_m = sv;
   endtask

   task automatic tick();
      slot_t e;
      logic  exp_rd;
      @(negedge clk);
      if (expq.size() > 0) e = expq.pop_front();
      else                 e = '{1'b0, 1'b0, 8'h00, 1'b0, 11};
      check(e.v ? 2 : 11, "out_valid", 8'(out_valid), 8'(e.v));   // R2 R11
      check(2, "out_soc", 8'(out_soc), 8'(e.soc));                 // R2
      if (e.v) check(e.tag, "out_data", out_data, e.d);
      exp_rd = (expq.size() > 0) ? expq[0].rd : 1'b0;
      check(3, "in_rd", 8'(in_rd), 8'(exp_rd));                    // R3
      if (rd_flag && feedq.size() > 0) void'(feedq.pop_front());
      in_data = (feedq.size() > 0) ? feedq[0] : 8'h00;
      rd_flag = in_rd;
      gfc_ser_in = (serq.size() > 0) ? serq.pop_front() : 1'($urandom);
      cell_avail = (mq.size() >= 53);
      slot_req   = req_on;
      if (req_on && expq.size() <= 1) build_cell();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic drain();
      req_on = 1'b0;
      while (expq.size() > 0) tick();
      tick();
   endtask

   task automatic add_cells(input int n);
      logic [7:0] b;
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 53; i++) begin
            b = 8'($urandom);
            feedq.push_back(b);
            mq.push_back(b);
         end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      n_cmp = 0; n_bad = 0; done = 0; rd_flag = 0; req_on = 0;
      hold_m = 4'h0;
      for (int i = 0; i < 43; i++) hist.push_back(1'b0);
      rst_n = 1'b0; slot_req = 0; cell_avail = 0; in_data = 0; gfc_ser_in = 0;
      cfg_hec_en = 1; cfg_scr_en = 0; cfg_idle_gfc = 0; cfg_idle_pti = 0;
      cfg_idle_clp = 1; cfg_gfc_mask = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(1, "reset out_valid", 8'(out_valid), 8'h00);
      check(1, "reset out_soc", 8'(out_soc), 8'h00);
      check(1, "reset in_rd", 8'(in_rd), 8'h00);
      rst_n = 1'b1;

      // R2 R3 R4 R5: assigned cells then idle fill, request held high
      add_cells(3);
      req_on = 1;
      run(250);
      drain();

      // R6 R11: check disabled, single-cycle requests with gaps
      cfg_hec_en = 0; cfg_idle_gfc = 4'hA; cfg_idle_pti = 3'b101; cfg_idle_clp = 0;
      add_cells(1);
      for (int k = 0; k < 5; k++) begin
         req_on = 1; tick();
         req_on = 0; run(60);
      end
      drain();

      // R7: scrambling across assigned and idle cells
      cfg_hec_en = 1; cfg_scr_en = 1;
      add_cells(4);
      req_on = 1;
      run(400);
      drain();

      // R8: bypass freezes history, then resume
      cfg_scr_en = 0;
      add_cells(2);
      req_on = 1; run(120); drain();
      cfg_scr_en = 1;
      add_cells(1);
      req_on = 1; run(120); drain();

      // R9 R10: per-bit serial GFC override
      cfg_gfc_mask = 4'b1010;
      add_cells(3);
      req_on = 1; run(250); drain();
      cfg_gfc_mask = 4'hF; cfg_idle_gfc = 4'h3;
      add_cells(2);
      req_on = 1; run(250); drain();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule